// File: doc/BRIEF.md
# Sponge AEAD Mode Sequencer

This block drives the mode of a sponge-based authenticated cipher whose state is 256 bits wide and whose rate is 128 bits. A start pulse latches the associated-data length, the message length (each up to 255 bytes) and an encrypt/decrypt selector, and seeds the state from a 128-bit nonce and a 128-bit key. The sequencer then walks through the associated-data blocks and the message blocks. For each block it first calls an external permutation through a level request and a one-cycle done strobe, then takes one 128-bit input block through a valid/ready handshake and XORs it into the low half of the state. The last short block of each phase is padded, and a domain-separation constant is folded into the top three state bytes together with the last block of each phase.

After the last block, one more permutation call is made and the low 16 state bytes are presented as the tag for one cycle. The permutation, the keystream shuffle that produces the output text, and tag comparison sit outside. They see the whole state on the `perm_state` port: during an absorb cycle it holds the freshly permuted state, and the mode output tells them which direction is active.

Top module: `sponge_aead_seq`

## Requirements
- R1: A start pulse is accepted only while `busy` is low; it latches both lengths and `dec_mode` (shown on `mode_o`, 1 = decrypt) and raises `busy` on the next cycle. A start pulse while `busy` is high has no effect on `mode_o` or on the sequence in progress.
- R2: An accepted start loads the state with nonce byte i in state byte i (bits 8i+7:8i) for i = 0..15 and key byte i in state byte 16+i.
- R3: Every input block is preceded by exactly one permutation call. `perm_req` is held high until `perm_done` is seen, and on that cycle the state is replaced by `perm_result`.
- R4: After each permutation call for a block, `in_ready` is high (never together with `perm_req`) and `in_is_msg` is 0 for associated data and 1 for the message. When `in_valid` is high, byte i of `in_data` (bits 8i+7:8i) is XORed into state byte i for i = 0..15.
- R5: A final block holding n < 16 remaining bytes is absorbed as its first n input bytes, then byte 0x01 at position n, then zero bytes; the unused input bytes have no effect. A final block of exactly 16 bytes is absorbed unpadded.
- R6: With non-empty associated data, the domain value applied with its last block is 1 if its length is a multiple of 16 and 2 otherwise, or 3 and 4 respectively when the message length is zero.
- R7: With a non-empty message, the domain value applied with its last block is 1 if its length is a multiple of 16 and 2 otherwise, or 5 and 6 respectively when the associated-data length is zero.
- R8: A domain value is applied by XORing 0x80 into state byte 29 if its bit 0 is set, into byte 30 if bit 1 is set and into byte 31 if bit 2 is set, in the same cycle as the last block of its phase.
- R9: When both lengths are zero, the start loads the state of R2 with 0x80 XORed into byte 29, no block is requested, and the next step is the tag permutation.
- R10: After the last block, one further permutation call is made. The cycle after its done strobe, `tag_valid` is high for exactly one cycle with `tag` equal to state bytes 0..15, and `busy` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new operation (accepted while idle) |
| dec_mode | input | 1 | 0 = encrypt, 1 = decrypt, latched at start |
| ad_len | input | 8 | Associated-data length in bytes |
| msg_len | input | 8 | Message length in bytes |
| nonce | input | 128 | Nonce, byte i in bits 8i+7:8i |
| key | input | 128 | Key, byte i in bits 8i+7:8i |
| busy | output | 1 | Operation in progress |
| mode_o | output | 1 | Latched direction |
| perm_req | output | 1 | Permutation request, held until done |
| perm_done | input | 1 | One-cycle completion strobe |
| perm_result | input | 256 | Permuted state, taken with `perm_done` |
| perm_state | output | 256 | Current state (permutation input and read port) |
| in_ready | output | 1 | Waiting for an input block |
| in_is_msg | output | 1 | Requested block belongs to the message |
| in_valid | input | 1 | Input block present |
| in_data | input | 128 | Input block, byte i in bits 8i+7:8i |
| tag_valid | output | 1 | Tag strobe |
| tag | output | 128 | Low 16 state bytes |

## Verification
The bench builds the block with its default parameters: 32 state bytes, a 16-byte rate and 8-bit lengths. These values bring lengths of 0, 5, 7, 16, 20, 32, 33 and 255 within reach, so runs of zero, one, two, three and sixteen blocks per phase are covered, each of the six domain values appears, and padding is tested at several cut points with non-zero filler bytes. A start pulse issued in the middle of a run, carrying the opposite direction and a different length, shows whether the block rejects a restart.

// File: rtl/sponge_seq_pkg.sv
// Shared types for the sponge AEAD sequencer.
// Assumes: nothing beyond the enum encoding being local to this block.
package sponge_seq_pkg;

    // Sequencer phase: each data phase alternates a permutation wait and an absorb slot.
    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_AD_PERM  = 3'd1,
        PH_AD_ABS   = 3'd2,
        PH_MSG_PERM = 3'd3,
        PH_MSG_ABS  = 3'd4,
        PH_TAG_PERM = 3'd5,
        PH_TAG_OUT  = 3'd6
    } phase_t;

endpackage

// File: rtl/sponge_block_pad.sv
// Pads one rate-sized input block to the number of bytes still owed.
// Bytes below cnt pass through, byte cnt becomes 0x01, bytes above become zero.
// Assumes: cnt is in 1..RATE_BYTES; cnt == RATE_BYTES passes the block unchanged.
module sponge_block_pad #(
    parameter int RATE_BYTES = 16,
    localparam int CNT_W     = $clog2(RATE_BYTES + 1),
    localparam int RATE_W    = 8 * RATE_BYTES
) (
    input  logic [RATE_W-1:0] blk_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [RATE_W-1:0] blk_o
);

    // One comparator pair per byte lane selects data, marker or zero.
    for (genvar i = 0; i < RATE_BYTES; i++) begin : g_lane
        localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
        assign blk_o[8*i +: 8] = (IDX < cnt_i)  ? blk_i[8*i +: 8] :
                                 (IDX == cnt_i) ? 8'h01 : 8'h00;
    end

endmodule

// File: rtl/sponge_domain_mask.sv
// Builds the domain-separation XOR mask for the top state bytes.
// Value: 1 for an aligned length, 2 otherwise; +2 for the associated-data
// phase when the message is empty; +4 for the message phase when the
// associated data are empty; forced to 1 for the empty/empty start case.
// Bit k of the value sets the top bit of byte STATE_BYTES-DOM_BITS+k.
// Assumes: DOM_BITS <= STATE_BYTES.
module sponge_domain_mask #(
    parameter int STATE_BYTES = 32,
    parameter int DOM_BITS    = 3,
    localparam int STATE_W    = 8 * STATE_BYTES,
    localparam int BASE_BYTE  = STATE_BYTES - DOM_BITS
) (
    input  logic               force_one_i,
    input  logic               is_msg_i,
    input  logic               ad_empty_i,
    input  logic               msg_empty_i,
    input  logic               aligned_i,
    output logic [STATE_W-1:0] mask_o
);

    logic [DOM_BITS-1:0] dom_val;

    // Derive the domain value from phase, emptiness and alignment.
    always_comb begin
        if (force_one_i) begin
            dom_val = DOM_BITS'(1);
        end else begin
            dom_val = aligned_i ? DOM_BITS'(1) : DOM_BITS'(2);
            if (!is_msg_i && msg_empty_i) dom_val = dom_val + DOM_BITS'(2);
            if (is_msg_i && ad_empty_i)   dom_val = dom_val + DOM_BITS'(4);
        end
    end

    // Spread the value bits over the top bits of the last bytes.
    for (genvar b = 0; b < STATE_BYTES; b++) begin : g_byte
        if (b >= BASE_BYTE) begin : g_dom
            assign mask_o[8*b +: 8] = {dom_val[b - BASE_BYTE], 7'b0};
        end else begin : g_zero
            assign mask_o[8*b +: 8] = 8'h00;
        end
    end

endmodule

// File: rtl/sponge_seq_ctrl.sv
// Phase controller: latches lengths and direction on start, counts the
// bytes left in the current phase, and steps through permutation waits,
// absorb slots and the tag step.
// Assumes: perm_done only arrives while perm_req is high; lengths fit LEN_W.
module sponge_seq_ctrl
    import sponge_seq_pkg::*;
#(
    parameter int RATE_BYTES = 16,
    parameter int LEN_W      = 8,
    localparam int CNT_W     = $clog2(RATE_BYTES + 1),
    localparam int ALIGN_W   = $clog2(RATE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dec_mode_i,
    input  logic [LEN_W-1:0] ad_len_i,
    input  logic [LEN_W-1:0] msg_len_i,
    input  logic             perm_done_i,
    input  logic             in_valid_i,
    output logic             busy_o,
    output logic             mode_o,
    output logic             perm_req_o,
    output logic             in_ready_o,
    output logic             in_is_msg_o,
    output logic             tag_valid_o,
    output logic             start_fire_o,
    output logic             start_empty_o,
    output logic             absorb_fire_o,
    output logic             last_blk_o,
    output logic [CNT_W-1:0] take_cnt_o,
    output logic             ad_empty_o,
    output logic             msg_empty_o,
    output logic             aligned_o
);

    localparam logic [LEN_W-1:0] RATE_LEN = LEN_W'(RATE_BYTES);

    phase_t           phase_q, phase_d;
    logic [LEN_W-1:0] rem_q, rem_d;
    logic [LEN_W-1:0] ad_len_q, msg_len_q;
    logic             mode_q;

    // Decode handshake and status outputs from the phase.
    always_comb begin
        busy_o        = (phase_q != PH_IDLE);
        perm_req_o    = (phase_q == PH_AD_PERM) || (phase_q == PH_MSG_PERM) ||
                        (phase_q == PH_TAG_PERM);
        in_ready_o    = (phase_q == PH_AD_ABS) || (phase_q == PH_MSG_ABS);
        in_is_msg_o   = (phase_q == PH_MSG_ABS);
        tag_valid_o   = (phase_q == PH_TAG_OUT);
        start_fire_o  = start_i && (phase_q == PH_IDLE);
        start_empty_o = start_fire_o && (ad_len_i == '0) && (msg_len_i == '0);
        absorb_fire_o = in_ready_o && in_valid_i;
    end

    // Size of the current block and whether it closes its phase.
    always_comb begin
        last_blk_o = (rem_q <= RATE_LEN);
        take_cnt_o = last_blk_o ? rem_q[CNT_W-1:0] : CNT_W'(RATE_BYTES);
        ad_empty_o  = (ad_len_q == '0);
        msg_empty_o = (msg_len_q == '0);
        aligned_o   = in_is_msg_o ? (msg_len_q[ALIGN_W-1:0] == '0)
                                  : (ad_len_q[ALIGN_W-1:0] == '0);
    end

    // Next phase and remaining-byte count.
    always_comb begin
        phase_d = phase_q;
        rem_d   = rem_q;
        case (phase_q)
            PH_IDLE: if (start_i) begin
                if (ad_len_i != '0) begin
                    phase_d = PH_AD_PERM;
                    rem_d   = ad_len_i;
                end else if (msg_len_i != '0) begin
                    phase_d = PH_MSG_PERM;
                    rem_d   = msg_len_i;
                end else begin
                    phase_d = PH_TAG_PERM;
                end
            end
            PH_AD_PERM:  if (perm_done_i) phase_d = PH_AD_ABS;
            PH_AD_ABS: if (in_valid_i) begin
                if (!last_blk_o) begin
                    phase_d = PH_AD_PERM;
                    rem_d   = rem_q - RATE_LEN;
                end else if (msg_len_q != '0) begin
                    phase_d = PH_MSG_PERM;
                    rem_d   = msg_len_q;
                end else begin
                    phase_d = PH_TAG_PERM;
                end
            end
            PH_MSG_PERM: if (perm_done_i) phase_d = PH_MSG_ABS;
            PH_MSG_ABS: if (in_valid_i) begin
                if (!last_blk_o) begin
                    phase_d = PH_MSG_PERM;
                    rem_d   = rem_q - RATE_LEN;
                end else begin
                    phase_d = PH_TAG_PERM;
                end
            end
            PH_TAG_PERM: if (perm_done_i) phase_d = PH_TAG_OUT;
            PH_TAG_OUT:  phase_d = PH_IDLE;
            default:     phase_d = PH_IDLE;
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            rem_q   <= '0;
        end else begin
            phase_q <= phase_d;
            rem_q   <= rem_d;
        end
    end

    // Operation parameters, captured only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_len_q  <= '0;
            msg_len_q <= '0;
            mode_q    <= 1'b0;
        end else if (start_fire_o) begin
            ad_len_q  <= ad_len_i;
            msg_len_q <= msg_len_i;
            mode_q    <= dec_mode_i;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/sponge_aead_seq.sv
// Sponge AEAD mode sequencer, top level. Owns the state register and its
// three write sources: the seed on start, the permutation result, and the
// padded block plus domain mask on absorb.
// Assumes: RATE_BYTES is a power of two and at most half of STATE_BYTES.
module sponge_aead_seq #(
    parameter int STATE_BYTES = 32,
    parameter int RATE_BYTES  = 16,
    parameter int LEN_W       = 8,
    parameter int DOM_BITS    = 3,
    localparam int STATE_W    = 8 * STATE_BYTES,
    localparam int RATE_W     = 8 * RATE_BYTES,
    localparam int CAP_W      = STATE_W - RATE_W,
    localparam int CNT_W      = $clog2(RATE_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               dec_mode,
    input  logic [LEN_W-1:0]   ad_len,
    input  logic [LEN_W-1:0]   msg_len,
    input  logic [RATE_W-1:0]  nonce,
    input  logic [CAP_W-1:0]   key,
    output logic               busy,
    output logic               mode_o,
    output logic               perm_req,
    input  logic               perm_done,
    input  logic [STATE_W-1:0] perm_result,
    output logic [STATE_W-1:0] perm_state,
    output logic               in_ready,
    output logic               in_is_msg,
    input  logic               in_valid,
    input  logic [RATE_W-1:0]  in_data,
    output logic               tag_valid,
    output logic [RATE_W-1:0]  tag
);

    logic               start_fire, start_empty, absorb_fire, last_blk;
    logic [CNT_W-1:0]   take_cnt;
    logic               ad_empty, msg_empty, aligned;
    logic [RATE_W-1:0]  padded;
    logic [STATE_W-1:0] dom_mask;
    logic [STATE_W-1:0] state_q;

    sponge_seq_ctrl #(
        .RATE_BYTES (RATE_BYTES),
        .LEN_W      (LEN_W)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .dec_mode_i    (dec_mode),
        .ad_len_i      (ad_len),
        .msg_len_i     (msg_len),
        .perm_done_i   (perm_done),
        .in_valid_i    (in_valid),
        .busy_o        (busy),
        .mode_o        (mode_o),
        .perm_req_o    (perm_req),
        .in_ready_o    (in_ready),
        .in_is_msg_o   (in_is_msg),
        .tag_valid_o   (tag_valid),
        .start_fire_o  (start_fire),
        .start_empty_o (start_empty),
        .absorb_fire_o (absorb_fire),
        .last_blk_o    (last_blk),
        .take_cnt_o    (take_cnt),
        .ad_empty_o    (ad_empty),
        .msg_empty_o   (msg_empty),
        .aligned_o     (aligned)
    );

    sponge_block_pad #(
        .RATE_BYTES (RATE_BYTES)
    ) i_pad (
        .blk_i (in_data),
        .cnt_i (take_cnt),
        .blk_o (padded)
    );

    sponge_domain_mask #(
        .STATE_BYTES (STATE_BYTES),
        .DOM_BITS    (DOM_BITS)
    ) i_dom (
        .force_one_i (start_fire),
        .is_msg_i    (in_is_msg),
        .ad_empty_i  (ad_empty),
        .msg_empty_i (msg_empty),
        .aligned_i   (aligned),
        .mask_o      (dom_mask)
    );

    // State register: seed, permutation result, or absorb with optional domain mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (start_fire) begin
            state_q <= {key, nonce} ^ (start_empty ? dom_mask : '0);
        end else if (perm_req && perm_done) begin
            state_q <= perm_result;
        end else if (absorb_fire) begin
            state_q <= state_q ^ {{CAP_W{1'b0}}, padded} ^ (last_blk ? dom_mask : '0);
        end
    end

    assign perm_state = state_q;
    assign tag        = state_q[RATE_W-1:0];

endmodule

// File: rtl/sponge_aead_seq_chk.sv
// Protocol checker for the sponge AEAD sequencer, bound to the top module.
// Assumes: synchronous active-low reset; checks only port-level behaviour.
module sponge_aead_seq_chk #(
    parameter int STATE_W = 256,
    parameter int RATE_W  = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [RATE_W-1:0]  nonce,
    input logic               busy,
    input logic               mode_o,
    input logic               perm_req,
    input logic               perm_done,
    input logic               in_ready,
    input logic               tag_valid,
    input logic [STATE_W-1:0] perm_state
);

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_o));                                            // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!perm_req && !in_ready && !tag_valid));                    // R1

    AST_SEED_NONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (perm_state[RATE_W-1:0] == $past(nonce)));       // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_req && !perm_done) |=> perm_req);                               // R3

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(perm_req && in_ready));                                             // R4

    AST_TAG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |=> (!tag_valid && !busy));                                 // R10

endmodule

bind sponge_aead_seq sponge_aead_seq_chk #(
    .STATE_W (STATE_W),
    .RATE_W  (RATE_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .nonce      (nonce),
    .busy       (busy),
    .mode_o     (mode_o),
    .perm_req   (perm_req),
    .perm_done  (perm_done),
    .in_ready   (in_ready),
    .tag_valid  (tag_valid),
    .perm_state (perm_state)
);

// File: tb/test_sponge_aead_seq.sv
// Bench for the sponge AEAD sequencer: acts as the permutation and data
// source, and keeps a behavioural model of the state built from the
// requirements, compared at every step of each run.
module test_sponge_aead_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dec_mode = 1'b0;
    logic [7:0]   ad_len = '0;
    logic [7:0]   msg_len = '0;
    logic [127:0] nonce = '0;
    logic [127:0] key = '0;
    logic         busy, mode_o, perm_req, in_ready, in_is_msg, tag_valid;
    logic         perm_done = 1'b0;
    logic [255:0] perm_result = '0;
    logic [255:0] perm_state;
    logic         in_valid = 1'b0;
    logic [127:0] in_data = '0;
    logic [127:0] tag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [255:0] mdl;

    sponge_aead_seq i_sponge_aead_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dec_mode    (dec_mode),
        .ad_len      (ad_len),
        .msg_len     (msg_len),
        .nonce       (nonce),
        .key         (key),
        .busy        (busy),
        .mode_o      (mode_o),
        .perm_req    (perm_req),
        .perm_done   (perm_done),
        .perm_result (perm_result),
        .perm_state  (perm_state),
        .in_ready    (in_ready),
        .in_is_msg   (in_is_msg),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .tag_valid   (tag_valid),
        .tag         (tag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%0d exp<=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Stand-in permutation: any fixed bijection serves.
    function automatic logic [255:0] perm_f(input logic [255:0] s);
        return {s[250:0], s[255:251]} ^ {8{32'h9E3779B9}};
    endfunction

    // Input block with every byte non-zero, so unpadded filler would show.
    function automatic logic [127:0] mk_blk(input int seed, input int b);
        logic [127:0] r;
        for (int j = 0; j < 16; j++) r[8*j +: 8] = 8'(seed * 37 + b * 11 + j * 13) | 8'h10;
        return r;
    endfunction

    // Padding as the requirement states it: n data bytes, 0x01, zeros.
    function automatic logic [127:0] pad_blk(input logic [127:0] d, input int n);
        logic [127:0] r;
        for (int j = 0; j < 16; j++)
            r[8*j +: 8] = (j < n) ? d[8*j +: 8] : (j == n) ? 8'h01 : 8'h00;
        return r;
    endfunction

    // Domain bits k = 0..2 land as 0x80 in bytes 29..31.
    function automatic logic [255:0] dom_mask(input int v);
        logic [255:0] m = '0;
        for (int k = 0; k < 3; k++) if (v[k]) m[8*(29+k) + 7] = 1'b1;
        return m;
    endfunction

    // One permutation call, optionally with a rejected restart in the middle.
    task automatic do_perm(input bit restart_probe, input bit exp_mode);
        while (!perm_req) @(negedge clk);
        chk(perm_state == mdl, "R3", "state at request", perm_state, mdl);
        if (restart_probe) begin
            start = 1'b1; dec_mode = ~exp_mode; ad_len = 8'd3; msg_len = 8'd9;
            @(negedge clk);
            start = 1'b0;
            chk(mode_o == exp_mode, "R1", "mode after restart while busy", 256'(mode_o), 256'(exp_mode));
        end else begin
            @(negedge clk);
        end
        chk(perm_req == 1'b1, "R3", "request held", 256'(perm_req), 256'd1);
        perm_done = 1'b1;
        perm_result = perm_f(mdl);
        @(negedge clk);
        perm_done = 1'b0;
        mdl = perm_f(mdl);
    endtask

    // One absorb slot; updates the model and compares the absorbed state.
    task automatic do_absorb(input bit is_msg, input logic [127:0] d, input int n,
                             input bit last, input int dom, input string req);
        logic [255:0] upd;
        chk(in_ready == 1'b1 && perm_req == 1'b0, "R4", "ready after permutation",
            256'({in_ready, perm_req}), 256'b10);
        chk(in_is_msg == is_msg, "R4", "phase flag", 256'(in_is_msg), 256'(is_msg));
        chk(perm_state == mdl, "R3", "permuted state visible", perm_state, mdl);
        in_valid = 1'b1;
        in_data = d;
        upd = mdl ^ {128'b0, (n < 16) ? pad_blk(d, n) : d};
        if (last) upd = upd ^ dom_mask(dom);
        @(negedge clk);
        in_valid = 1'b0;
        mdl = upd;
        chk(perm_state == mdl, req, "state after absorb", perm_state, mdl);
    endtask

    // Full run: start, associated data, message, tag.
    task automatic run_case(input int a, input int m, input bit dec, input bit probe);
        int rem;
        int b;
        int dv;
        logic [255:0] init;
        string req;
        nonce = {4{32'h01234567 ^ 32'(a * 257 + m)}};
        key   = {4{32'hC0DEF00D ^ 32'(m * 131 + a)}};
        @(negedge clk);
        start = 1'b1; dec_mode = dec; ad_len = 8'(a); msg_len = 8'(m);
        @(negedge clk);
        start = 1'b0;
        init = {key, nonce};
        chk(busy == 1'b1, "R1", "busy after start", 256'(busy), 256'd1);
        chk(mode_o == dec, "R1", "mode latched", 256'(mode_o), 256'(dec));
        if (a == 0 && m == 0) begin
            init = init ^ dom_mask(1);
            chk(perm_state == init, "R9", "empty seed", perm_state, init);
            chk(perm_req == 1'b1 && in_ready == 1'b0, "R9", "straight to tag",
                256'({perm_req, in_ready}), 256'b10);
        end else begin
            chk(perm_state == init, "R2", "seed", perm_state, init);
        end
        mdl = init;
        rem = a; b = 0;
        while (rem > 0) begin
            do_perm(probe && b == 0, dec);
            dv = (a % 16 == 0) ? 1 : 2;
            if (m == 0) dv += 2;
            req = (rem <= 16) ? ((rem < 16) ? "R5 R6 R8" : "R6 R8") : "R4";
            do_absorb(1'b0, mk_blk(a, b), (rem < 16) ? rem : 16, rem <= 16, dv, req);
            rem -= 16; b++;
        end
        rem = m; b = 0;
        while (rem > 0) begin
            do_perm(1'b0, dec);
            dv = (m % 16 == 0) ? 1 : 2;
            if (a == 0) dv += 4;
            req = (rem <= 16) ? ((rem < 16) ? "R5 R7 R8" : "R7 R8") : "R4";
            do_absorb(1'b1, mk_blk(m + 99, b), (rem < 16) ? rem : 16, rem <= 16, dv, req);
            rem -= 16; b++;
        end
        do_perm(1'b0, dec);
        chk(tag_valid == 1'b1, "R10", "tag strobe", 256'(tag_valid), 256'd1);
        chk(tag == mdl[127:0], "R10", "tag value", 256'(tag), 256'(mdl[127:0]));
        @(negedge clk);
        chk(tag_valid == 1'b0 && busy == 1'b0, "R10", "strobe ends, idle",
            256'({tag_valid, busy}), 256'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && perm_req == 1'b0 && in_ready == 1'b0 && tag_valid == 1'b0,
            "R1", "reset state", 256'({busy, perm_req, in_ready, tag_valid}), 256'd0);
        chk(perm_state == '0, "R1", "reset state value", perm_state, 256'd0);
        run_case(0,   0,   1'b0, 1'b0);  // R9
        run_case(16,  0,   1'b0, 1'b0);  // R6 value 3
        run_case(5,   0,   1'b1, 1'b0);  // R6 value 4, R5
        run_case(0,   32,  1'b0, 1'b0);  // R7 value 5
        run_case(0,   7,   1'b1, 1'b0);  // R7 value 6, R5
        run_case(20,  33,  1'b0, 1'b1);  // R6/R7 value 2, restart probe R1
        run_case(32,  16,  1'b1, 1'b0);  // R6/R7 value 1
        run_case(255, 255, 1'b0, 1'b0);  // length limit, R5 at 15 bytes
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule